// File: doc/BRIEF.md
# Timer Channel Count Latch and Read-Back Port

This block is the processor-facing register logic of a single programmable timer channel. It takes control bytes and count bytes from an 8-bit write port. It assembles a 16-bit initial count and hands it to the counting element, which is a separate block. It serves the count and a status byte back over an 8-bit read port.

The block can freeze a copy of the live count, so that software reading a free-running counter one byte at a time gets both bytes from the same value. A read-back command can also freeze a status byte that reports three things: the OUT level, whether the last written count is still waiting to be loaded, and the six programmed control bits. The read path and the write path each keep their own byte pointer, so reads and writes to the channel may be interleaved.

Top module: `tmr_latch_rb`

## Requirements
- R1: After reset `null_count_o` is 1, `count_wr_o` is 0 and the stored control field is 6'h30 (two-byte access, mode 0, binary). `mode_o` and `bcd_o` are 0.
- R2: A control write is `wr_i` with `sel_ctrl_i`=1, `wdata_i[7:6]`≠2'b11 and `wdata_i[5:4]`≠2'b00. It stores `wdata_i[5:0]`, clears both byte pointers, discards any pending count and status snapshot, and sets the null-count flag. In the stored field, bits 5:4 are the access mode (01 low byte only, 10 high byte only, 11 low then high), bits 3:1 are the mode, and bit 0 is the BCD flag.
- R3: `mode_o` equals stored bits 3:1, except that 6 reads as 2 and 7 reads as 3. `bcd_o` equals stored bit 0.
- R4: A data write is `wr_i` with `sel_ctrl_i`=0. In low-only mode a data write commits {8'h00,byte}. In high-only mode it commits {byte,8'h00}. In two-byte mode the first write holds the low byte and the second write commits {high,low}. On the cycle after the edge that commits a count, `count_wr_o` is 1 and `count_o` shows the new count; at all other times `count_wr_o` is 0.
- R5: The null-count flag is set by a control write or a count commit. It is cleared by `load_i` when it is not being set on the same edge, and setting wins over clearing.
- R6: Without a snapshot, a read returns a byte of the live `count_i`: the low byte in low-only mode, the high byte in high-only mode, and low then high in two-byte mode.
- R7: A latch command is a control write with `wdata_i[7:6]`≠2'b11 and `wdata_i[5:4]`=2'b00. It freezes `count_i` at that edge and leaves the stored control field unchanged. Reads then return the frozen value until its last byte for the current access mode has been read.
- R8: A count latch request that arrives while a snapshot is pending is ignored, and the frozen value is kept.
- R9: A read-back command is a control write with `wdata_i[7:6]`=2'b11. Bit 5 set requests a count latch. Bit 4 set freezes the status byte {out_i, null-count, control[5:0]} as it stands at that edge. A second status request while one is pending is ignored.
- R10: When both a status byte and a count are frozen, the first read returns the status byte and the count bytes follow.
- R11: Data writes do not move the read pointer, and reads do not move the write pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, one byte per cycle |
| rd_i | input | 1 | Read strobe; the pointer advances at the edge |
| sel_ctrl_i | input | 1 | 1 selects the control register for writes |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the current read slot |
| count_i | input | 16 | Live count from the counting element |
| out_i | input | 1 | Current OUT level of the channel |
| load_i | input | 1 | Counting element has taken the committed count |
| count_o | output | 16 | Last committed initial count |
| count_wr_o | output | 1 | One-cycle pulse when a new count is committed |
| null_count_o | output | 1 | Committed count not yet loaded |
| mode_o | output | 3 | Effective operating mode |
| bcd_o | output | 1 | BCD counting selected |

## Verification
A byte pointer in the wrong state shows on the very next read or write: either the wrong half of the count appears on `rdata_o`, or `count_o` commits one write early or one write late. A snapshot that is not held, or not released, is exposed within one read. The returned byte then follows the live counter while it should be frozen, or stays frozen after the last byte has been read. A status byte captured at the wrong edge, or returned out of order, shows as a mismatch in the OUT bit, the null-count bit or the control bits on the first read that follows the read-back command.

// File: rtl/tmr_lrb_pkg.sv
package tmr_lrb_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int CTL_W  = 6;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_BOTH  = 2'b11
  } acc_e;

  localparam logic [1:0] CMD_RDBK = 2'b11;

  // true when the byte about to be transferred ends the access sequence
  function automatic logic last_byte(acc_e acc, logic tog);
    return (acc != ACC_BOTH) || tog;
  endfunction
endpackage

// File: rtl/tmr_lrb_ctrl.sv
module tmr_lrb_ctrl
  import tmr_lrb_pkg::*;
#(
  parameter logic [CTL_W-1:0] RST_CTRL = 6'h30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              sel_ctrl_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [CTL_W-1:0]  ctrl_o,
  output acc_e              acc_o,
  output logic [2:0]        mode_o,
  output logic              bcd_o,
  output logic              cw_load_o,
  output logic              cnt_latch_o,
  output logic              sts_latch_o
);
  logic             ctrl_wr, is_rdbk, is_latch;
  logic [CTL_W-1:0] ctrl_q;
  logic [2:0]       raw_mode;

  assign ctrl_wr  = wr_i & sel_ctrl_i;
  assign is_rdbk  = (wdata_i[7:6] == CMD_RDBK);
  assign is_latch = !is_rdbk && (wdata_i[5:4] == ACC_LATCH);

  assign cw_load_o   = ctrl_wr & !is_rdbk & !is_latch;
  assign cnt_latch_o = ctrl_wr & (is_latch | (is_rdbk & wdata_i[5]));
  assign sts_latch_o = ctrl_wr & is_rdbk & wdata_i[4];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= RST_CTRL;
    else if (cw_load_o) ctrl_q <= wdata_i[CTL_W-1:0];
  end

  assign ctrl_o   = ctrl_q;
  assign acc_o    = acc_e'(ctrl_q[5:4]);
  assign raw_mode = ctrl_q[3:1];
  // modes 6 and 7 fold onto 2 and 3
  assign mode_o   = raw_mode[1] ? {1'b0, raw_mode[1:0]} : raw_mode;
  assign bcd_o    = ctrl_q[0];

  p_cw_store_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw_load_o |=> ctrl_q == $past(wdata_i[CTL_W-1:0]));
  p_latch_keeps_ctrl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && !cw_load_o) |=> $stable(ctrl_q));
  p_acc_never_latch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_o != ACC_LATCH);
endmodule

// File: rtl/tmr_lrb_wr.sv
module tmr_lrb_wr
  import tmr_lrb_pkg::*;
#(
  parameter logic NULL_RST = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              data_wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  acc_e              acc_i,
  input  logic              cw_load_i,
  input  logic              load_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              count_wr_o,
  output logic              null_o
);
  logic              wr_tog_q, commit;
  logic [BYTE_W-1:0] lo_q;
  logic [CNT_W-1:0]  count_q;
  logic              pulse_q, null_q;

  assign commit = data_wr_i && (acc_i != ACC_LATCH) && last_byte(acc_i, wr_tog_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_tog_q <= 1'b0;
      lo_q     <= '0;
      count_q  <= '0;
      pulse_q  <= 1'b0;
    end else begin
      pulse_q <= commit;
      if (cw_load_i) begin
        wr_tog_q <= 1'b0;
      end else if (data_wr_i) begin
        unique case (acc_i)
          ACC_LO:   count_q <= {{BYTE_W{1'b0}}, wdata_i};
          ACC_HI:   count_q <= {wdata_i, {BYTE_W{1'b0}}};
          ACC_BOTH: begin
            if (!wr_tog_q) lo_q <= wdata_i;
            else           count_q <= {wdata_i, lo_q};
            wr_tog_q <= !wr_tog_q;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  null_q <= NULL_RST;
    else if (cw_load_i || commit) null_q <= 1'b1;
    else if (load_i)              null_q <= 1'b0;
  end

  assign count_o    = count_q;
  assign count_wr_o = pulse_q;
  assign null_o     = null_q;

  p_null_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cw_load_i || commit) |=> null_q);
  p_commit_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_wr_o |-> $past(data_wr_i));
  p_wptr_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw_load_i |=> !wr_tog_q);
  p_count_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_wr_i |=> $stable(count_q));
endmodule

// File: rtl/tmr_lrb_rd.sv
module tmr_lrb_rd
  import tmr_lrb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              cw_load_i,
  input  logic              cnt_latch_i,
  input  logic              sts_latch_i,
  input  acc_e              acc_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              out_i,
  input  logic              null_i,
  input  logic [CTL_W-1:0]  ctrl_i,
  output logic [BYTE_W-1:0] rdata_o
);
  logic [CNT_W-1:0]  cnt_lat_q, src;
  logic              cnt_vld_q, sts_vld_q, rd_tog_q;
  logic [BYTE_W-1:0] sts_lat_q, sts_now;

  assign sts_now = {out_i, null_i, ctrl_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_lat_q <= '0;
      cnt_vld_q <= 1'b0;
      sts_lat_q <= '0;
      sts_vld_q <= 1'b0;
      rd_tog_q  <= 1'b0;
    end else if (cw_load_i) begin
      cnt_vld_q <= 1'b0;
      sts_vld_q <= 1'b0;
      rd_tog_q  <= 1'b0;
    end else begin
      if (rd_i) begin
        if (sts_vld_q) begin
          sts_vld_q <= 1'b0;
        end else begin
          if (acc_i == ACC_BOTH) rd_tog_q <= !rd_tog_q;
          if (last_byte(acc_i, rd_tog_q)) cnt_vld_q <= 1'b0;
        end
      end
      if (cnt_latch_i && !cnt_vld_q) begin
        cnt_lat_q <= count_i;
        cnt_vld_q <= 1'b1;
        rd_tog_q  <= 1'b0;
      end
      if (sts_latch_i && !sts_vld_q) begin
        sts_lat_q <= sts_now;
        sts_vld_q <= 1'b1;
      end
    end
  end

  assign src = cnt_vld_q ? cnt_lat_q : count_i;

  always_comb begin
    if (sts_vld_q) rdata_o = sts_lat_q;
    else begin
      unique case (acc_i)
        ACC_HI:   rdata_o = src[CNT_W-1:BYTE_W];
        ACC_BOTH: rdata_o = rd_tog_q ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
        default:  rdata_o = src[BYTE_W-1:0];
      endcase
    end
  end

  p_lat_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_vld_q && !cw_load_i && !rd_i) |=> (cnt_vld_q && $stable(cnt_lat_q)));
  p_sts_first_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_vld_q && rd_i && !cw_load_i && !cnt_latch_i) |=>
      ($stable(cnt_vld_q) && $stable(rd_tog_q)));
  p_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_vld_q && !sts_vld_q && rd_i && last_byte(acc_i, rd_tog_q) && !cnt_latch_i) |=> !cnt_vld_q);
  p_sts_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_vld_q && !rd_i && !cw_load_i) |=> (sts_vld_q && $stable(sts_lat_q)));
endmodule

// File: rtl/tmr_latch_rb.sv
module tmr_latch_rb
  import tmr_lrb_pkg::*;
#(
  parameter logic [CTL_W-1:0] RST_CTRL = 6'h30,
  parameter logic             NULL_RST = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              sel_ctrl_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              out_i,
  input  logic              load_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              count_wr_o,
  output logic              null_count_o,
  output logic [2:0]        mode_o,
  output logic              bcd_o
);
  logic [CTL_W-1:0] ctrl;
  acc_e             acc;
  logic             cw_load, cnt_latch, sts_latch, data_wr;

  assign data_wr = wr_i & !sel_ctrl_i;

  tmr_lrb_ctrl #(.RST_CTRL(RST_CTRL)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_i),
    .sel_ctrl_i  (sel_ctrl_i),
    .wdata_i     (wdata_i),
    .ctrl_o      (ctrl),
    .acc_o       (acc),
    .mode_o      (mode_o),
    .bcd_o       (bcd_o),
    .cw_load_o   (cw_load),
    .cnt_latch_o (cnt_latch),
    .sts_latch_o (sts_latch)
  );

  tmr_lrb_wr #(.NULL_RST(NULL_RST)) u_wr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .data_wr_i  (data_wr),
    .wdata_i    (wdata_i),
    .acc_i      (acc),
    .cw_load_i  (cw_load),
    .load_i     (load_i),
    .count_o    (count_o),
    .count_wr_o (count_wr_o),
    .null_o     (null_count_o)
  );

  tmr_lrb_rd u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_i        (rd_i),
    .cw_load_i   (cw_load),
    .cnt_latch_i (cnt_latch),
    .sts_latch_i (sts_latch),
    .acc_i       (acc),
    .count_i     (count_i),
    .out_i       (out_i),
    .null_i      (null_count_o),
    .ctrl_i      (ctrl),
    .rdata_o     (rdata_o)
  );

  p_wr_rd_indep_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !sel_ctrl_i) |-> !cw_load);
endmodule

// File: tb/tmr_latch_rb_bench.sv
module tmr_latch_rb_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0, sel = 1'b0, out = 1'b0, load = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [15:0] live = 16'h1234;
  logic [15:0] cnt_o;
  logic        cnt_wr, nullc, bcd;
  logic [2:0]  mode;
  int          n_cmp = 0, n_bad = 0;
  logic        done = 1'b0;

  always #4 clk = ~clk;
  always @(negedge clk) live <= live + 16'h0107;

  tmr_latch_rb u_tmr_latch_rb (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .sel_ctrl_i(sel),
    .wdata_i(wdata), .rdata_o(rdata), .count_i(live), .out_i(out),
    .load_i(load), .count_o(cnt_o), .count_wr_o(cnt_wr),
    .null_count_o(nullc), .mode_o(mode), .bcd_o(bcd)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // one write; seen = count_i at the capturing edge
  task automatic wr_op(input logic s, input logic [7:0] d, output logic [15:0] seen);
    @(negedge clk); wr = 1'b1; sel = s; wdata = d;
    @(posedge clk); seen = live;
    @(negedge clk); wr = 1'b0; sel = 1'b0; #1;
  endtask

  task automatic rd_op(output logic [7:0] b, output logic [15:0] lv);
    @(negedge clk); rd = 1'b1;
    #3 b = rdata; lv = live;
    @(negedge clk); rd = 1'b0; #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] s1, s2, lv;
    logic [7:0]  b;
    logic [2:0]  em;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 null", {15'b0, nullc}, 16'd1);
    chk("R1 pulse", {15'b0, cnt_wr}, 16'd0);
    chk("R1 mode", {13'b0, mode}, 16'd0);
    chk("R1 bcd", {15'b0, bcd}, 16'd0);
    wr_op(1'b1, 8'hD0, s1);
    rd_op(b, lv);
    chk("R1 status", {8'h0, b}, 16'h0070);

    // R2 R3 R9 mode sweep with status read-back
    for (int m = 0; m < 8; m++) begin
      for (int z = 0; z < 2; z++) begin
        logic [7:0] cw;
        cw = {2'b00, 2'b11, m[2:0], z[0]};
        wr_op(1'b1, cw, s1);
        em = (m == 6) ? 3'd2 : (m == 7) ? 3'd3 : m[2:0];
        chk("R3 mode", {13'b0, mode}, {13'b0, em});
        chk("R3 bcd", {15'b0, bcd}, {15'b0, z[0]});
        chk("R2 null", {15'b0, nullc}, 16'd1);
        out = m[0] ^ z[0];
        wr_op(1'b1, 8'hD0, s1);
        rd_op(b, lv);
        chk("R9 status", {8'h0, b}, {8'h0, out, 1'b1, cw[5:0]});
      end
    end

    // R4 R5 low-only and high-only writes
    for (int v = 0; v < 256; v += 37) begin
      wr_op(1'b1, 8'h10, s1);
      wr_op(1'b0, v[7:0], s1);
      chk("R4 lo pulse", {15'b0, cnt_wr}, 16'd1);
      chk("R4 lo value", cnt_o, {8'h00, v[7:0]});
      @(negedge clk); load = 1'b1; @(negedge clk); load = 1'b0; #1;
      chk("R4 pulse ends", {15'b0, cnt_wr}, 16'd0);
      chk("R5 load clears", {15'b0, nullc}, 16'd0);
      wr_op(1'b1, 8'h20, s1);
      wr_op(1'b0, v[7:0] ^ 8'h5A, s1);
      chk("R4 hi value", cnt_o, {v[7:0] ^ 8'h5A, 8'h00});
      chk("R5 commit sets", {15'b0, nullc}, 16'd1);
    end
    // R4 two-byte
    for (int v = 0; v < 4; v++) begin
      wr_op(1'b1, 8'h30, s1);
      wr_op(1'b0, 8'h11 * v[7:0], s1);
      chk("R4 first byte no pulse", {15'b0, cnt_wr}, 16'd0);
      wr_op(1'b0, 8'hC3 - v[7:0], s1);
      chk("R4 both pulse", {15'b0, cnt_wr}, 16'd1);
      chk("R4 both value", cnt_o, {8'hC3 - v[7:0], 8'h11 * v[7:0]});
    end
    // R5 set wins over clear
    @(negedge clk); load = 1'b1; wr = 1'b1; sel = 1'b1; wdata = 8'h30;
    @(negedge clk); load = 1'b0; wr = 1'b0; sel = 1'b0; #1;
    chk("R5 set wins", {15'b0, nullc}, 16'd1);

    // R6 live reads
    for (int k = 0; k < 4; k++) begin
      wr_op(1'b1, 8'h10, s1);
      rd_op(b, lv); chk("R6 lo", {8'h0, b}, {8'h0, lv[7:0]});
      wr_op(1'b1, 8'h20, s1);
      rd_op(b, lv); chk("R6 hi", {8'h0, b}, {8'h0, lv[15:8]});
      wr_op(1'b1, 8'h30, s1);
      rd_op(b, lv); chk("R6 both lo", {8'h0, b}, {8'h0, lv[7:0]});
      rd_op(b, lv); chk("R6 both hi", {8'h0, b}, {8'h0, lv[15:8]});
    end

    // R7 latch two-byte and low-only, release after last byte
    for (int k = 0; k < 3; k++) begin
      wr_op(1'b1, 8'h30, s1);
      wr_op(1'b1, 8'h00, s1);
      idle(3 + k);
      rd_op(b, lv); chk("R7 lat lo", {8'h0, b}, {8'h0, s1[7:0]});
      idle(2);
      rd_op(b, lv); chk("R7 lat hi", {8'h0, b}, {8'h0, s1[15:8]});
      rd_op(b, lv); chk("R7 released", {8'h0, b}, {8'h0, lv[7:0]});
      rd_op(b, lv);
      chk("R7 ctrl kept", {13'b0, mode}, 16'd0);
    end
    wr_op(1'b1, 8'h10, s1);
    wr_op(1'b1, 8'h00, s1);
    idle(4);
    rd_op(b, lv); chk("R7 lo-only lat", {8'h0, b}, {8'h0, s1[7:0]});
    rd_op(b, lv); chk("R7 lo-only released", {8'h0, b}, {8'h0, lv[7:0]});

    // R8 second latch ignored
    wr_op(1'b1, 8'h30, s1);
    wr_op(1'b1, 8'h00, s1);
    idle(3);
    wr_op(1'b1, 8'h00, s2);
    wr_op(1'b1, 8'hE0, s2);
    rd_op(b, lv); chk("R8 first kept lo", {8'h0, b}, {8'h0, s1[7:0]});
    rd_op(b, lv); chk("R8 first kept hi", {8'h0, b}, {8'h0, s1[15:8]});

    // R9 R10 status then count
    wr_op(1'b1, 8'h36, s1);
    out = 1'b1;
    wr_op(1'b1, 8'hF0, s1);
    out = 1'b0;
    idle(2);
    rd_op(b, lv); chk("R10 status first", {8'h0, b}, 16'h00F6);
    rd_op(b, lv); chk("R10 count lo", {8'h0, b}, {8'h0, s1[7:0]});
    rd_op(b, lv); chk("R10 count hi", {8'h0, b}, {8'h0, s1[15:8]});
    // R9 repeated status request ignored
    out = 1'b1;
    wr_op(1'b1, 8'hD0, s1);
    out = 1'b0;
    wr_op(1'b1, 8'hD0, s1);
    rd_op(b, lv); chk("R9 second status ignored", {8'h0, b}, 16'h00F6);
    rd_op(b, lv); chk("R9 status consumed", {8'h0, b}, {8'h0, lv[7:0]});
    rd_op(b, lv);

    // R11 interleaved read and write pointers
    wr_op(1'b1, 8'h34, s2);
    wr_op(1'b1, 8'h00, s1);
    rd_op(b, lv); chk("R11 rd lo", {8'h0, b}, {8'h0, s1[7:0]});
    wr_op(1'b0, 8'hAB, s2);
    rd_op(b, lv); chk("R11 rd hi", {8'h0, b}, {8'h0, s1[15:8]});
    wr_op(1'b0, 8'hCD, s2);
    chk("R11 write value", cnt_o, 16'hCDAB);
    chk("R11 write pulse", {15'b0, cnt_wr}, 16'd1);

    // R2 control write resets pointers and discards snapshot
    wr_op(1'b1, 8'h00, s1);
    rd_op(b, lv);
    wr_op(1'b0, 8'h11, s2);
    wr_op(1'b1, 8'h30, s2);
    rd_op(b, lv); chk("R2 latch dropped", {8'h0, b}, {8'h0, lv[7:0]});
    wr_op(1'b0, 8'h22, s2);
    wr_op(1'b0, 8'h33, s2);
    chk("R2 wptr reset", cnt_o, 16'h3322);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule